// File: doc/BRIEF.md
# Two-Level Maskable Interrupt Controller

This block collects interrupt events for a small microcontroller core and decides when the core must divert to its service routine. Three local sources (a timer overflow, an external pin edge and a port-change event) have their flags and enables in a control register. A parameterised number of peripheral flag registers, each paired with an enable register, hold the remaining sources. All of these registers are reached through a simple single-cycle register bus. Each event pulse sets its flag bit, whatever the masks say. The masks only decide whether a request is raised.

A request needs three things: the global enable, a flag with its own enable set, and, for peripheral sources, the peripheral group enable as well. The request is offered to the core and is taken only on an instruction-boundary strobe. On acceptance the controller clears the global enable in hardware. It then pulses an acknowledge, together with a push-return-address strobe and the fixed vector address. It stays in service until the core signals return-from-interrupt, which sets the global enable again. The instruction decoder, the stack and the peripherals are outside the block and are reached only through these strobes.

Top module: `intr_ctrl`

## Requirements
- R1: After reset every register reads 0, including the global enable at bit 7 of the control register, and irq_req_o, irq_ack_o and push_o are low.
- R2: An event pulse sampled on a clock edge sets its flag bit at that edge, with any value of its enable, the group enable or the global enable. Local flag positions are timer bit 2, external pin bit 1 and port change bit 0. Peripheral event bit i*8+k sets bit k of peripheral flag register i.
- R3: Flags are cleared only by register writes. If a write of 0 and an event hit the same flag in the same cycle, the flag is 1 afterwards, and an acknowledge leaves all flags unchanged.
- R4: irq_req_o is high in a cycle only if, one cycle earlier, the global enable was set and some source was pending: for a local source its flag with its enable, and for a peripheral source its flag with its enable and the group enable. It is never high while in service.
- R5: When boundary_i and irq_req_o are both high on an edge, irq_ack_o and push_o are high for exactly the next cycle, vec_o shows 0x0004 in that cycle and 0 otherwise, and the global enable reads 0.
- R6: reti_i while in service sets the global enable and returns to idle. reti_i outside service changes nothing.
- R7: A register write clearing the global enable in the same cycle as an acceptance does not stop the acknowledge. The enable reads 0 during service, and the later return sets it to 1.
- R8: With boundary_i held high, an enabled local event sampled on edge k gives irq_req_o high after edge k+1 and irq_ack_o high after edge k+2.
- R9: Register addresses: 0 is the control register, 1+i is peripheral flag register i, and 1+NPREG+i is peripheral enable register i. Control bits: 7 global enable, 6 group enable, 5 timer enable, 4 external pin enable, 3 port-change enable, 2..0 flags. Other addresses read 0.
- R10: A peripheral flag with its enable set raises no request while the group enable (control bit 6) is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_addr_i | input | ADDR_W | Register address |
| reg_we_i | input | 1 | Register write strobe |
| reg_wdata_i | input | 8 | Register write data |
| reg_rdata_o | output | 8 | Register read data (combinational) |
| tmr_evt_i | input | 1 | Timer overflow event pulse |
| ext_evt_i | input | 1 | External pin event pulse |
| pchg_evt_i | input | 1 | Port change event pulse |
| per_evt_i | input | NPREG*8 | Peripheral event pulses |
| boundary_i | input | 1 | Instruction boundary strobe from the core |
| reti_i | input | 1 | Return-from-interrupt strobe from the core |
| irq_req_o | output | 1 | Interrupt request to the core |
| irq_ack_o | output | 1 | Acceptance pulse |
| push_o | output | 1 | Push return address strobe |
| vec_o | output | PC_W | Vector address during acceptance |

## Verification
Two pairs of functions can land in the same cycle. A software write that clears the global enable can meet the acceptance of a request. A software write of 0 to a flag can meet a hardware event on that flag. The bench provokes both on purpose. It drives the clearing write together with the boundary strobe while a request is pending. It also pulses an event during a write of zero to the same flag. It then judges the outcome at the ports: the acknowledge must still appear, the read-back enable must be 0 in service and 1 after return, and the flag must read 1. Random traffic meets the same collisions by chance and is compared on every cycle against a model built from the requirements.

// File: rtl/intr_pkg.sv
`timescale 1ns/1ps
package intr_pkg;
  localparam int DW       = 8;
  localparam int NLOCAL   = 3;
  localparam int GIE_B    = 7;
  localparam int PEIE_B   = 6;
  localparam int EN_HI_B  = 5;
  localparam int EN_LO_B  = 3;
  localparam int FL_HI_B  = 2;
  localparam int FL_LO_B  = 0;
  localparam int CTRL_ADR = 0;

  typedef enum logic {ST_IDLE = 1'b0, ST_SVC = 1'b1} seq_state_e;
endpackage

// File: rtl/intr_ctrl_reg.sv
`timescale 1ns/1ps
module intr_ctrl_reg
  import intr_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  logic [DW-1:0]     wdata_i,
  input  logic [NLOCAL-1:0] evt_i,     // {timer, ext pin, port change}
  input  logic              gie_clr_i,
  input  logic              gie_set_i,
  output logic [DW-1:0]     ctrl_o
);
  logic [DW-1:0] q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      q <= '0;
    end else begin
      q[PEIE_B:EN_LO_B] <= wr_i ? wdata_i[PEIE_B:EN_LO_B] : q[PEIE_B:EN_LO_B];
      // hardware set beats a software clear
      q[FL_HI_B:FL_LO_B] <= (wr_i ? wdata_i[FL_HI_B:FL_LO_B] : q[FL_HI_B:FL_LO_B]) | evt_i;
      // return beats acceptance beats software
      if (gie_set_i)      q[GIE_B] <= 1'b1;
      else if (gie_clr_i) q[GIE_B] <= 1'b0;
      else if (wr_i)      q[GIE_B] <= wdata_i[GIE_B];
    end
  end

  assign ctrl_o = q;
endmodule

// File: rtl/intr_flag_bank.sv
`timescale 1ns/1ps
module intr_flag_bank #(
  parameter int NREG = 2,
  parameter int W    = 8
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic [NREG-1:0]       flag_we_i,
  input  logic [NREG-1:0]       en_we_i,
  input  logic [W-1:0]          wdata_i,
  input  logic [NREG-1:0][W-1:0] evt_i,
  output logic [NREG-1:0][W-1:0] flag_o,
  output logic [NREG-1:0][W-1:0] en_o,
  output logic                  hit_o
);
  logic [NREG-1:0] reg_hit;

  for (genvar g = 0; g < NREG; g++) begin : g_reg
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        flag_o[g] <= '0;
        en_o[g]   <= '0;
      end else begin
        flag_o[g] <= (flag_we_i[g] ? wdata_i : flag_o[g]) | evt_i[g];
        if (en_we_i[g]) en_o[g] <= wdata_i;
      end
    end
    assign reg_hit[g] = |(flag_o[g] & en_o[g]);
  end

  assign hit_o = |reg_hit;
endmodule

// File: rtl/intr_mask_eval.sv
`timescale 1ns/1ps
module intr_mask_eval
  import intr_pkg::*;
(
  input  logic [DW-1:0] ctrl_i,
  input  logic          periph_hit_i,
  output logic          pending_o
);
  logic local_hit;

  // enables at 5..3 line up with flags at 2..0
  assign local_hit = |(ctrl_i[EN_HI_B:EN_LO_B] & ctrl_i[FL_HI_B:FL_LO_B]);
  assign pending_o = ctrl_i[GIE_B] & (local_hit | (ctrl_i[PEIE_B] & periph_hit_i));
endmodule

// File: rtl/intr_seq.sv
`timescale 1ns/1ps
module intr_seq
  import intr_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic pending_i,
  input  logic boundary_i,
  input  logic reti_i,
  output logic req_o,
  output logic ack_o,
  output logic in_svc_o,
  output logic gie_clr_o,
  output logic gie_set_o
);
  seq_state_e state_q;
  logic       pend_q;
  logic       accept;

  assign in_svc_o  = (state_q == ST_SVC);
  assign req_o     = pend_q & ~in_svc_o;
  assign accept    = boundary_i & req_o;
  assign gie_clr_o = accept;
  assign gie_set_o = reti_i & in_svc_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      pend_q  <= 1'b0;
      ack_o   <= 1'b0;
    end else begin
      pend_q <= pending_i;
      ack_o  <= accept;
      if (accept)         state_q <= ST_SVC;
      else if (gie_set_o) state_q <= ST_IDLE;
    end
  end
endmodule

// File: rtl/intr_ctrl.sv
`timescale 1ns/1ps
module intr_ctrl
  import intr_pkg::*;
#(
  parameter int              NPREG    = 2,
  parameter int              ADDR_W   = 3,
  parameter int              PC_W     = 13,
  parameter logic [PC_W-1:0] VEC_ADDR = 13'h0004
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [ADDR_W-1:0]   reg_addr_i,
  input  logic                reg_we_i,
  input  logic [DW-1:0]       reg_wdata_i,
  output logic [DW-1:0]       reg_rdata_o,
  input  logic                tmr_evt_i,
  input  logic                ext_evt_i,
  input  logic                pchg_evt_i,
  input  logic [NPREG*DW-1:0] per_evt_i,
  input  logic                boundary_i,
  input  logic                reti_i,
  output logic                irq_req_o,
  output logic                irq_ack_o,
  output logic                push_o,
  output logic [PC_W-1:0]     vec_o
);
  localparam int FLAG_BASE = 1;
  localparam int EN_BASE   = FLAG_BASE + NPREG;

  logic [DW-1:0]             ctrl;
  logic                      ctrl_we;
  logic [NPREG-1:0]          flag_we, en_we;
  logic [NPREG-1:0][DW-1:0]  pflag, pen;
  logic                      periph_hit, pending;
  logic                      gie, in_svc, gie_clr, gie_set;

  assign ctrl_we = reg_we_i && (reg_addr_i == ADDR_W'(CTRL_ADR));

  for (genvar g = 0; g < NPREG; g++) begin : g_dec
    assign flag_we[g] = reg_we_i && (reg_addr_i == ADDR_W'(FLAG_BASE + g));
    assign en_we[g]   = reg_we_i && (reg_addr_i == ADDR_W'(EN_BASE + g));
  end

  intr_ctrl_reg u_ctrl (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_i      (ctrl_we),
    .wdata_i   (reg_wdata_i),
    .evt_i     ({tmr_evt_i, ext_evt_i, pchg_evt_i}),
    .gie_clr_i (gie_clr),
    .gie_set_i (gie_set),
    .ctrl_o    (ctrl)
  );

  intr_flag_bank #(.NREG(NPREG), .W(DW)) u_bank (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .flag_we_i (flag_we),
    .en_we_i   (en_we),
    .wdata_i   (reg_wdata_i),
    .evt_i     (per_evt_i),
    .flag_o    (pflag),
    .en_o      (pen),
    .hit_o     (periph_hit)
  );

  intr_mask_eval u_mask (
    .ctrl_i       (ctrl),
    .periph_hit_i (periph_hit),
    .pending_o    (pending)
  );

  intr_seq u_seq (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .pending_i  (pending),
    .boundary_i (boundary_i),
    .reti_i     (reti_i),
    .req_o      (irq_req_o),
    .ack_o      (irq_ack_o),
    .in_svc_o   (in_svc),
    .gie_clr_o  (gie_clr),
    .gie_set_o  (gie_set)
  );

  assign gie    = ctrl[GIE_B];
  assign push_o = irq_ack_o;
  assign vec_o  = irq_ack_o ? VEC_ADDR : '0;

  always_comb begin
    reg_rdata_o = '0;
    if (reg_addr_i == ADDR_W'(CTRL_ADR)) reg_rdata_o = ctrl;
    for (int i = 0; i < NPREG; i++) begin
      if (reg_addr_i == ADDR_W'(FLAG_BASE + i)) reg_rdata_o = pflag[i];
      if (reg_addr_i == ADDR_W'(EN_BASE + i))   reg_rdata_o = pen[i];
    end
  end
endmodule

// File: rtl/intr_ctrl_chk.sv
`timescale 1ns/1ps
module intr_ctrl_chk #(
  parameter int              PC_W     = 13,
  parameter logic [PC_W-1:0] VEC_ADDR = 13'h0004
) (
  input logic            clk_i,
  input logic            rst_ni,
  input logic            boundary_i,
  input logic            reti_i,
  input logic            irq_req_o,
  input logic            irq_ack_o,
  input logic            push_o,
  input logic [PC_W-1:0] vec_o,
  input logic            gie_i,
  input logic            in_svc_i
);
  AST_ACK_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_ack_o |=> !irq_ack_o);                                           // R5
  AST_ACK_AT_BOUNDARY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_ack_o |-> $past(boundary_i && irq_req_o));                        // R5
  AST_VEC_ON_ACK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_ack_o |-> (push_o && vec_o == VEC_ADDR));                         // R5
  AST_GIE_LOW_ON_ACK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_ack_o |-> !gie_i);                                               // R7
  AST_REQ_NEEDS_GIE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_req_o |-> $past(gie_i));                                         // R4
  AST_RETI_RESTORES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reti_i && in_svc_i) |=> (gie_i && !in_svc_i));                      // R6
  AST_NO_REQ_IN_SVC: assert property (@(posedge clk_i) disable iff (!rst_ni)
    in_svc_i |-> !irq_req_o);                                            // R4
endmodule

bind intr_ctrl intr_ctrl_chk #(.PC_W(PC_W), .VEC_ADDR(VEC_ADDR)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .boundary_i (boundary_i),
  .reti_i     (reti_i),
  .irq_req_o  (irq_req_o),
  .irq_ack_o  (irq_ack_o),
  .push_o     (push_o),
  .vec_o      (vec_o),
  .gie_i      (gie),
  .in_svc_i   (in_svc)
);

// File: tb/intr_ctrl_test.sv
`timescale 1ns/1ps
module intr_ctrl_test;
  localparam int NPREG = 2;
  localparam int AW    = 3;
  localparam int PCW   = 13;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic [AW-1:0]   reg_addr = '0;
  logic            reg_we = 1'b0;
  logic [7:0]      reg_wdata = '0;
  logic [7:0]      reg_rdata;
  logic            tmr_evt = 1'b0, ext_evt = 1'b0, pchg_evt = 1'b0;
  logic [NPREG*8-1:0] per_evt = '0;
  logic            boundary = 1'b0, reti = 1'b0;
  logic            irq_req, irq_ack, push;
  logic [PCW-1:0]  vec;

  int n_cmp = 0, n_bad = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  intr_ctrl #(.NPREG(NPREG), .ADDR_W(AW), .PC_W(PCW)) uut (
    .clk_i(clk), .rst_ni(rst_n),
    .reg_addr_i(reg_addr), .reg_we_i(reg_we), .reg_wdata_i(reg_wdata), .reg_rdata_o(reg_rdata),
    .tmr_evt_i(tmr_evt), .ext_evt_i(ext_evt), .pchg_evt_i(pchg_evt), .per_evt_i(per_evt),
    .boundary_i(boundary), .reti_i(reti),
    .irq_req_o(irq_req), .irq_ack_o(irq_ack), .push_o(push), .vec_o(vec)
  );

  task automatic chk(string tag, logic [15:0] act, logic [15:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // reference model built from the requirements
  logic [7:0] m_ctrl;
  logic [7:0] m_pf [NPREG];
  logic [7:0] m_pe [NPREG];
  bit m_pend, m_svc, m_ack;

  function automatic logic [7:0] m_read(int a);
    if (a == 0) return m_ctrl;
    for (int i = 0; i < NPREG; i++) begin
      if (a == 1 + i) return m_pf[i];
      if (a == 1 + NPREG + i) return m_pe[i];
    end
    return 8'h00;
  endfunction

  function automatic bit m_pending();
    bit ph = 1'b0;
    for (int i = 0; i < NPREG; i++) ph |= |(m_pf[i] & m_pe[i]);
    return m_ctrl[7] && ((|(m_ctrl[5:3] & m_ctrl[2:0])) || (m_ctrl[6] && ph));
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_ctrl = '0; m_pend = 0; m_svc = 0; m_ack = 0;
      for (int i = 0; i < NPREG; i++) begin m_pf[i] = '0; m_pe[i] = '0; end
    end else begin
      bit acc, pn, nsvc, w0, rt;
      logic [7:0] c;
      acc = boundary && m_pend && !m_svc;
      rt  = reti && m_svc;
      pn  = m_pending();
      w0  = reg_we && (int'(reg_addr) == 0);
      c   = m_ctrl;
      if (w0) c[6:0] = reg_wdata[6:0];
      c[2:0] = c[2:0] | {tmr_evt, ext_evt, pchg_evt};
      if (rt) c[7] = 1'b1; else if (acc) c[7] = 1'b0; else if (w0) c[7] = reg_wdata[7];
      for (int i = 0; i < NPREG; i++) begin
        if (reg_we && int'(reg_addr) == 1 + i) m_pf[i] = reg_wdata;
        m_pf[i] = m_pf[i] | per_evt[i*8 +: 8];
        if (reg_we && int'(reg_addr) == 1 + NPREG + i) m_pe[i] = reg_wdata;
      end
      nsvc = acc ? 1'b1 : (rt ? 1'b0 : m_svc);
      m_ctrl = c; m_pend = pn; m_ack = acc; m_svc = nsvc;
    end
  end

  always @(negedge clk) begin
    if (rst_n && !done) begin
      chk("R4 req",   {15'd0, irq_req}, {15'd0, m_pend && !m_svc});
      chk("R5 ack",   {15'd0, irq_ack}, {15'd0, m_ack});
      chk("R5 push",  {15'd0, push},    {15'd0, m_ack});
      chk("R5 vec",   {3'd0, vec},      m_ack ? 16'h0004 : 16'h0000);
      chk("R9 rdata", {8'd0, reg_rdata}, {8'd0, m_read(int'(reg_addr))});
    end
  end

  task automatic step();
    @(posedge clk); #1;
  endtask

  task automatic wr(int a, logic [7:0] d);
    reg_addr = AW'(a); reg_we = 1'b1; reg_wdata = d;
    step();
    reg_we = 1'b0;
  endtask

  task automatic rd(int a, output logic [7:0] d);
    reg_addr = AW'(a); #0.5;
    d = reg_rdata;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_cmp++; n_bad++;
    $display("FAIL watchdog: actual=hung expected=done");
    finish_run();
  end

  initial begin
    logic [7:0] d;
    void'($urandom(32'd1234));
    repeat (3) step();
    // reset state
    for (int a = 0; a < 5; a++) begin rd(a, d); chk("R1 reset reg", {8'd0, d}, 16'h0); end
    chk("R1 reset req", {15'd0, irq_req}, 16'h0);
    rst_n = 1'b1;
    step();
    for (int a = 0; a < 6; a++) begin rd(a, d); chk("R1 reg after release", {8'd0, d}, 16'h0); end
    chk("R1 ack", {15'd0, irq_ack}, 16'h0);

    // R2: flags latch with every mask clear
    tmr_evt = 1; ext_evt = 1; pchg_evt = 1; per_evt = 16'h3CA5;
    step();
    tmr_evt = 0; ext_evt = 0; pchg_evt = 0; per_evt = '0;
    rd(0, d); chk("R2 local flags", {8'd0, d}, 16'h0007);
    rd(1, d); chk("R2 pflag0", {8'd0, d}, 16'h00A5);
    rd(2, d); chk("R2 pflag1", {8'd0, d}, 16'h003C);
    step(); chk("R2 no req while masked", {15'd0, irq_req}, 16'h0);

    // R3: hardware set beats software clear
    ext_evt = 1; wr(0, 8'h00); ext_evt = 0;
    rd(0, d); chk("R3 ext set beats clear", {8'd0, d}, 16'h0002);
    wr(0, 8'h00); rd(0, d); chk("R3 sw clear", {8'd0, d}, 16'h0000);
    per_evt = 16'h0001; wr(1, 8'h00); per_evt = '0;
    rd(1, d); chk("R3 pflag set beats clear", {8'd0, d}, 16'h0001);
    wr(2, 8'h00);

    // R10: group gate, then R4 request
    wr(3, 8'h01);
    wr(0, 8'h80);
    step(); step(); step();
    chk("R10 gated by group enable", {15'd0, irq_req}, 16'h0);
    wr(0, 8'hC0);
    chk("R4 req one cycle late", {15'd0, irq_req}, 16'h0);
    step();
    chk("R4 req raised", {15'd0, irq_req}, 16'h1);

    // R5 acceptance
    boundary = 1; step(); boundary = 0;
    chk("R5 ack", {15'd0, irq_ack}, 16'h1);
    chk("R5 push", {15'd0, push}, 16'h1);
    chk("R5 vector", {3'd0, vec}, 16'h0004);
    rd(0, d); chk("R5 gie cleared", {8'd0, d}, 16'h0040);
    rd(1, d); chk("R3 flag kept on ack", {8'd0, d}, 16'h0001);
    step();
    chk("R5 ack single", {15'd0, irq_ack}, 16'h0);
    chk("R4 no req in service", {15'd0, irq_req}, 16'h0);

    // R6 return
    reti = 1; step(); reti = 0;
    rd(0, d); chk("R6 reti sets gie", {8'd0, d}, 16'h00C0);
    step(); step();
    chk("R4 req again after return", {15'd0, irq_req}, 16'h1);
    wr(1, 8'h00); wr(0, 8'h00);
    reti = 1; step(); reti = 0;
    rd(0, d); chk("R6 reti outside service ignored", {8'd0, d}, 16'h0000);

    // R7: clear of gie collides with acceptance
    wr(0, 8'h90);
    ext_evt = 1; step(); ext_evt = 0;
    step();
    chk("R7 req before race", {15'd0, irq_req}, 16'h1);
    reg_addr = 0; reg_we = 1; reg_wdata = 8'h12; boundary = 1;
    step();
    reg_we = 0; boundary = 0;
    chk("R7 ack despite clear", {15'd0, irq_ack}, 16'h1);
    rd(0, d); chk("R7 gie reads 0", {8'd0, d}, 16'h0012);
    reti = 1; step(); reti = 0;
    rd(0, d); chk("R7 return re-enables", {8'd0, d}, 16'h0092);
    wr(0, 8'h00);

    // R8 latency
    wr(0, 8'h90);
    boundary = 1;
    ext_evt = 1; step(); ext_evt = 0;
    chk("R8 no req at k", {15'd0, irq_req}, 16'h0);
    step();
    chk("R8 req at k+1", {15'd0, irq_req}, 16'h1);
    chk("R8 no ack at k+1", {15'd0, irq_ack}, 16'h0);
    step();
    chk("R8 ack at k+2", {15'd0, irq_ack}, 16'h1);
    boundary = 0;
    reti = 1; step(); reti = 0;
    wr(0, 8'h00);

    // constrained random traffic against the model
    for (int n = 0; n < 4000; n++) begin
      reg_addr  = AW'($urandom_range(0, 5));
      reg_we    = ($urandom_range(0, 3) == 0);
      reg_wdata = 8'($urandom);
      tmr_evt   = ($urandom_range(0, 7) == 0);
      ext_evt   = ($urandom_range(0, 7) == 0);
      pchg_evt  = ($urandom_range(0, 7) == 0);
      per_evt   = 16'($urandom & $urandom & $urandom);
      boundary  = $urandom_range(0, 1) == 1;
      reti      = ($urandom_range(0, 5) == 0);
      step();
    end
    reg_we = 0; tmr_evt = 0; ext_evt = 0; pchg_evt = 0; per_evt = '0; boundary = 0; reti = 0;
    step(); step();
    finish_run();
  end
endmodule